// File: doc/BRIEF.md
# Carrier Presence Qualifier

This block decides whether a valid received FSK carrier is on the line. A level estimator upstream delivers an amplitude code with a one-cycle strobe about every 51 µs (about 19.46 kHz). The qualifier compares each code against a turn-on threshold while no carrier is declared, and against a turn-off threshold about 3 dB lower while a carrier is declared. Both thresholds come from a single programmed value, so their spacing is always kept.

A retriggerable hold window bridges short gaps between samples above the threshold. A long qualification timer and a short release timer, both counted in strobe ticks and both programmable, then decide when the active-low detect output changes. Typical settings are 12451 ticks to declare a carrier (0.64 s) and 1051 ticks to release it (0.054 s). The received-data output is clamped high whenever no carrier is declared.

Top module: `carrier_qual`

## Requirements
- R1: After reset, `cd_n` is 1 and `rxd_out` is 1, and both qualification timers are cleared.
- R2: With no carrier declared, `cd_n` falls on the strobe that completes `on_len` consecutive present strobes. A strobe is present when `lvl_code >= thr_on`, or when it falls inside the hold window. `cd_n` is registered and changes at that strobe's clock edge.
- R3: While no carrier is declared, a strobe that is not present clears the on timer, so counting restarts from zero.
- R4: With a carrier declared, `cd_n` rises on the strobe that completes `off_len` consecutive strobes that are not present. In this state a strobe is present when `lvl_code >= thr_off`, or when it falls inside the hold window.
- R5: While a carrier is declared, a present strobe clears the off timer.
- R6: The turn-off threshold is `thr_off = floor(thr_on * 181 / 256)`, about 3 dB below `thr_on`. Both comparisons are "greater or equal". A level between the two thresholds keeps the current state.
- R7: Each strobe whose level is at or above the active threshold reloads a window of `HOLD` strobes. The next `HOLD` strobes below the threshold still count as present.
- R8: While `cd_n` is 1, `rxd_out` is 1. While `cd_n` is 0, `rxd_out` equals `rxd_in`.
- R9: A length of 0 in `on_len` or `off_len` acts as a length of 1.
- R10: Cycles without `lvl_stb` change neither `cd_n` nor any timer, whatever the level code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_stb | input | 1 | Strobe marking a new level sample |
| lvl_code | input | LW | Level estimate sample |
| thr_on | input | LW | Turn-on threshold; the turn-off threshold is derived from it |
| on_len | input | CW | Qualification length in strobes |
| off_len | input | CW | Release length in strobes |
| rxd_in | input | 1 | Demodulated receive data |
| cd_n | output | 1 | Carrier detect, active low |
| rxd_out | output | 1 | Receive data, clamped high with no carrier |

## Verification
The bench builds the block with `HOLD` = 3 in place of the 117-strobe window. This brings window expiry within a few strobes, so short dropouts can be set against long ones on exact strobe counts. It keeps the default widths (12-bit level, 16-bit lengths) and programs lengths of 10 and 4 strobes, or 0. With these values, the exact strobe of each output change, the timer clears, the threshold boundaries at 200/141/140 and the zero-length case are each reached within a few dozen strobes.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
    // turn-off threshold = thr_on * OFF_NUM / 2**OFF_SHIFT (about -3 dB)
    localparam int OFF_NUM   = 181;
    localparam int OFF_SHIFT = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOCK = 1'b1
    } cd_state_e;
endpackage

// File: rtl/cdq_thresh.sv
module cdq_thresh #(
    parameter int LW = 12
) (
    input  logic [LW-1:0] lvl_code,
    input  logic [LW-1:0] thr_on,
    input  logic          locked,
    output logic          above
);
    import cdq_pkg::*;

    localparam int PW = LW + OFF_SHIFT;

    logic [PW-1:0] prod;
    logic [LW-1:0] thr_off;

    always_comb begin
        prod    = PW'(thr_on) * PW'(OFF_NUM);
        thr_off = prod[PW-1:OFF_SHIFT];
        above   = locked ? (lvl_code >= thr_off) : (lvl_code >= thr_on);
    end
endmodule

// File: rtl/cdq_hold.sv
module cdq_hold #(
    parameter int HOLD = 117
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic above,
    output logic present
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [HW-1:0] win;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        present = above || (s_q.win != '0);
        if (stb) begin
            if (above)
                s_d.win = HW'(HOLD);
            else if (s_q.win != '0)
                s_d.win = s_q.win - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cdq_qual.sv
module cdq_qual #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          present,
    input  logic [CW-1:0] on_len,
    input  logic [CW-1:0] off_len,
    output logic          locked
);
    import cdq_pkg::*;

    typedef struct packed {
        cd_state_e     st;
        logic [CW-1:0] on_cnt;
        logic [CW-1:0] off_cnt;
    } qual_t;

    qual_t s_d, s_q;
    logic [CW:0] on_nxt, off_nxt;

    always_comb begin
        s_d     = s_q;
        on_nxt  = {1'b0, s_q.on_cnt} + 1'b1;
        off_nxt = {1'b0, s_q.off_cnt} + 1'b1;
        if (stb) begin
            if (s_q.st == ST_IDLE) begin
                s_d.off_cnt = '0;
                if (!present) begin
                    s_d.on_cnt = '0;
                end else if (on_nxt >= {1'b0, on_len}) begin
                    s_d.st     = ST_LOCK;
                    s_d.on_cnt = '0;
                end else begin
                    s_d.on_cnt = on_nxt[CW-1:0];
                end
            end else begin
                s_d.on_cnt = '0;
                if (present) begin
                    s_d.off_cnt = '0;
                end else if (off_nxt >= {1'b0, off_len}) begin
                    s_d.st      = ST_IDLE;
                    s_d.off_cnt = '0;
                end else begin
                    s_d.off_cnt = off_nxt[CW-1:0];
                end
            end
        end
        locked = (s_q.st == ST_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, on_cnt: '0, off_cnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/carrier_qual.sv
module carrier_qual #(
    parameter int LW   = 12,
    parameter int CW   = 16,
    parameter int HOLD = 117
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_stb,
    input  logic [LW-1:0] lvl_code,
    input  logic [LW-1:0] thr_on,
    input  logic [CW-1:0] on_len,
    input  logic [CW-1:0] off_len,
    input  logic          rxd_in,
    output logic          cd_n,
    output logic          rxd_out
);
    logic above;
    logic present;
    logic locked;

    cdq_thresh #(.LW(LW)) u_thresh (
        .lvl_code (lvl_code),
        .thr_on   (thr_on),
        .locked   (locked),
        .above    (above)
    );

    cdq_hold #(.HOLD(HOLD)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (lvl_stb),
        .above   (above),
        .present (present)
    );

    cdq_qual #(.CW(CW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (lvl_stb),
        .present (present),
        .on_len  (on_len),
        .off_len (off_len),
        .locked  (locked)
    );

    always_comb begin
        cd_n    = ~locked;
        rxd_out = rxd_in | ~locked;
    end
endmodule

// File: rtl/cdq_check.sv
module cdq_check #(
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lvl_stb,
    input logic [LW-1:0] lvl_code,
    input logic [LW-1:0] thr_on,
    input logic          cd_n,
    input logic          rxd_in,
    input logic          rxd_out
);
    logic [LW+7:0] ref_prod;
    logic [LW-1:0] ref_off;

    always_comb begin
        ref_prod = (LW+8)'(thr_on) * (LW+8)'(181);
        ref_off  = ref_prod[LW+7:8];
    end

    a_r10_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_stb |=> $stable(cd_n));

    a_r2_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> $past(lvl_stb));

    a_r4_rise_below_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_n) |-> ($past(lvl_stb) && ($past(lvl_code) < $past(ref_off))));

    a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        cd_n |-> rxd_out);

    a_r8_pass_data: assert property (@(posedge clk) disable iff (!rst_n)
        !cd_n |-> (rxd_out == rxd_in));
endmodule

bind carrier_qual cdq_check #(.LW(LW)) u_cdq_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_stb  (lvl_stb),
    .lvl_code (lvl_code),
    .thr_on   (thr_on),
    .cd_n     (cd_n),
    .rxd_in   (rxd_in),
    .rxd_out  (rxd_out)
);

// File: tb/test_carrier_qual.sv
`timescale 1ns/1ps
module test_carrier_qual;
    localparam int LW = 12;
    localparam int CW = 16;
    localparam int HOLD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lvl_stb = 1'b0;
    logic [LW-1:0] lvl_code = '0;
    logic [LW-1:0] thr_on = 12'd200;
    logic [CW-1:0] on_len = 16'd10;
    logic [CW-1:0] off_len = 16'd4;
    logic          rxd_in = 1'b0;
    logic          cd_n;
    logic          rxd_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    carrier_qual #(.LW(LW), .CW(CW), .HOLD(HOLD)) i_carrier_qual (
        .clk(clk), .rst_n(rst_n), .lvl_stb(lvl_stb), .lvl_code(lvl_code),
        .thr_on(thr_on), .on_len(on_len), .off_len(off_len),
        .rxd_in(rxd_in), .cd_n(cd_n), .rxd_out(rxd_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lvl_stb = 1'b0; lvl_code = '0;
        thr_on = 12'd200; on_len = 16'd10; off_len = 16'd4; rxd_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one strobe; returns just after the edge that registered it
    task automatic strobe(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lvl_code = LW'(code); lvl_stb = 1'b1;
            @(negedge clk);
            lvl_stb = 1'b0;
        end
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 cd_n after reset", cd_n, 1'b1);
        chk("R8 rxd clamped after reset", rxd_out, 1'b1);
    endtask

    task automatic t_on();
        do_reset();
        strobe(200, 9);
        chk("R2 still idle after 9 strobes", cd_n, 1'b1);
        strobe(200, 1);
        chk("R2 detect after 10th strobe (R6 equal level)", cd_n, 1'b0);
    endtask

    task automatic t_no_strobe();
        do_reset();
        lvl_code = 12'd4000;
        repeat (50) @(negedge clk);
        #1;
        chk("R10 no strobes no change", cd_n, 1'b1);
        strobe(300, 10);
        chk("R10 lock after strobes", cd_n, 1'b0);
        lvl_code = 12'd0;
        repeat (50) @(negedge clk);
        #1;
        chk("R10 no release without strobes", cd_n, 1'b0);
    endtask

    task automatic t_short_gap();
        do_reset();
        strobe(300, 5);
        strobe(0, 3);
        strobe(300, 1);
        chk("R7 gap bridged, 9 strobes", cd_n, 1'b1);
        strobe(300, 1);
        chk("R7 gap bridged, detect at 10", cd_n, 1'b0);
    endtask

    task automatic t_long_gap();
        do_reset();
        strobe(300, 5);
        strobe(0, 4);
        strobe(300, 9);
        chk("R3 timer restarted", cd_n, 1'b1);
        strobe(300, 1);
        chk("R3 detect after fresh 10", cd_n, 1'b0);
    endtask

    task automatic t_off();
        do_reset();
        strobe(300, 10);
        rxd_in = 1'b0; #1;
        chk("R8 data passes low", rxd_out, 1'b0);
        rxd_in = 1'b1; #1;
        chk("R8 data passes high", rxd_out, 1'b1);
        rxd_in = 1'b0;
        strobe(0, 6);
        chk("R4 held for hold+off-1", cd_n, 1'b0);
        strobe(0, 1);
        chk("R4 released at hold+off", cd_n, 1'b1);
        chk("R8 clamp after release", rxd_out, 1'b1);
    endtask

    task automatic t_off_clear();
        do_reset();
        strobe(300, 10);
        strobe(0, 5);
        strobe(300, 1);
        strobe(0, 6);
        chk("R5 off timer cleared", cd_n, 1'b0);
        strobe(0, 1);
        chk("R5 release after full count", cd_n, 1'b1);
    endtask

    task automatic t_hyst();
        do_reset();
        strobe(199, 30);
        chk("R6 below turn-on never detects", cd_n, 1'b1);
        strobe(200, 10);
        chk("R6 lock", cd_n, 1'b0);
        strobe(141, 40);
        chk("R6 level at turn-off keeps lock", cd_n, 1'b0);
        strobe(140, 6);
        chk("R6 below turn-off, still in window+count", cd_n, 1'b0);
        strobe(140, 1);
        chk("R6 release below turn-off", cd_n, 1'b1);
    endtask

    task automatic t_len0();
        do_reset();
        on_len = '0; off_len = '0;
        strobe(300, 1);
        chk("R9 zero on length detects at once", cd_n, 1'b0);
        strobe(0, 3);
        chk("R9 window still holds", cd_n, 1'b0);
        strobe(0, 1);
        chk("R9 zero off length releases at once", cd_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_on();
        t_no_strobe();
        t_short_gap();
        t_long_gap();
        t_off();
        t_off_clear();
        t_hyst();
        t_len0();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule